// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator with Common Shift Chain

This block produces the row-scan timing for a 64-row dot-matrix LCD. It also carries the frame-start token across the common (row) outputs. In master mode, a prescaled time unit derived from the system clock drives a 2-bit phase counter and a row counter. From these counters the block builds its timing outputs:

- two non-overlapping phase clocks, each low for one unit out of four;
- a line clock with a period of four units;
- a frame pulse that stays high for the first line of every 64;
- an AC-inversion signal that toggles at each frame start.

In slave mode the internal generators stay in their reset state. The line clock, frame pulse and inversion signal then come from input pins, and the phase clocks are held high.

The row outputs come from a 64-stage shift register that moves one stage per active line-clock edge. A phase-select input chooses whether the rising or the falling line-clock edge is active. A direction input chooses which of the two link pins is the serial input and which is the serial output. The output pin carries the last stage in the chosen direction, and its output-enable is raised. Because the token enters on one link pin and leaves on the other, several devices can be chained.

Top module: `lcd_com_timing`

## Requirements
- R1: After reset is released in master mode, row_o is all zero, m_o is 0, frm_o is 1, cl2_o is 1, phi1_o is 0 and phi2_o is 1.
- R2: In master mode, with n clocks since reset release and unit u = (n / TICK_DIV) mod 4, phi1_o is low only when u = 0 and phi2_o is low only when u = 2, so phi1_o and phi2_o are never low together.
- R3: In master mode cl2_o is high when u is 0 or 1 and low when u is 2 or 3, so its period is 4*TICK_DIV clocks and it rises as phi1_o falls.
- R4: In master mode frm_o is high exactly during line 0, where line = (n / (4*TICK_DIV)) mod ROWS. It rises together with cl2_o.
- R5: In master mode m_o is 0 during the first frame after reset and inverts at each frame start: m_o = (n / (4*TICK_DIV*ROWS)) mod 2.
- R6: With dir_i = 1, link_a_i is the serial input. It enters stage 0, data moves toward stage ROWS-1, link_b_o carries stage ROWS-1 with link_b_oe_o = 1 and link_a_oe_o = 0, and link_b_i is ignored.
- R7: With dir_i = 0, link_b_i is the serial input. It enters stage ROWS-1, data moves toward stage 0, link_a_o carries stage 0 with link_a_oe_o = 1 and link_b_oe_o = 0, and link_a_i is ignored.
- R8: With edge_rise_i = 1 the chain shifts once per rising cl2_o edge, and with edge_rise_i = 0 it shifts once per falling edge. The shift takes effect on the clock after the line-clock edge is seen, and at no other time.
- R9: With master_i = 0, cl2_o, frm_o and m_o follow ext_cl2_i, ext_frm_i and ext_m_i, phi1_o and phi2_o are held at 1, and ext_cl2_i edges drive the chain.
- R10: Bit k of row_o is stage k of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: internal timing, 0: slave (external timing) |
| dir_i | input | 1 | Shift direction and link pin roles |
| edge_rise_i | input | 1 | 1: shift on rising line-clock edge, 0: falling |
| ext_cl2_i | input | 1 | External line clock (slave mode) |
| ext_frm_i | input | 1 | External frame pulse (slave mode) |
| ext_m_i | input | 1 | External AC-inversion signal (slave mode) |
| link_a_i | input | 1 | Link pin A input value |
| link_b_i | input | 1 | Link pin B input value |
| link_a_o | output | 1 | Link pin A output value (stage 0) |
| link_b_o | output | 1 | Link pin B output value (stage ROWS-1) |
| link_a_oe_o | output | 1 | Link pin A output enable |
| link_b_oe_o | output | 1 | Link pin B output enable |
| phi1_o | output | 1 | Phase clock 1 |
| phi2_o | output | 1 | Phase clock 2 |
| cl2_o | output | 1 | Line (shift) clock |
| frm_o | output | 1 | Frame pulse |
| m_o | output | 1 | AC-inversion signal |
| row_o | output | ROWS | Row (common) outputs, one bit per stage |

## Verification
The timing outputs are checked cycle by cycle across more than two full frames. This shows that the phase offset, the line period, the frame wrap at line 63 and the inversion toggle all come out right, rather than only looking plausible at the start. A single token is walked through the chain in both directions and for both edge polarities. During these runs the unused link pin is driven with the inverse of the serial data, so any leak from the wrong pin or any shift on the wrong edge puts a different pattern on row_o or on the exit pin. In the slave run, the external line clock, frame pulse and inversion signal are driven at unrelated rates, so a pass-through wired to the wrong input, or an edge taken from the internal clock, shows up as a mismatch.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;
  localparam int unsigned UNITS_PER_LINE = 4;

  typedef struct packed {
    logic phi1;
    logic phi2;
    logic cl2;
    logic frm;
    logic m;
  } scan_t;
endpackage

// File: rtl/lcd_com_timebase.sv
module lcd_com_timebase
  import lcd_com_pkg::*;
#(
  parameter int unsigned TICK_DIV = 175,
  parameter int unsigned ROWS     = 64
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  output scan_t scan_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  logic [PW-1:0] pre_q;
  logic [1:0]    unit_q;
  logic [RW-1:0] row_q;
  logic          m_q;
  logic          tick;
  logic          line_end;

  assign tick     = (pre_q == PRE_LAST);
  assign line_end = tick && (unit_q == 2'(UNITS_PER_LINE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      unit_q <= '0;
      row_q  <= '0;
      m_q    <= 1'b0;
    end else if (!run_i) begin
      pre_q  <= '0;
      unit_q <= '0;
      row_q  <= '0;
      m_q    <= 1'b0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) unit_q <= unit_q + 2'd1;
      if (line_end) begin
        if (row_q == ROW_LAST) begin
          row_q <= '0;
          m_q   <= ~m_q;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end
    end
  end

  // phase clocks are held high while the generator is parked
  always_comb begin
    scan_o.phi1 = !run_i || (unit_q != 2'd0);
    scan_o.phi2 = !run_i || (unit_q != 2'd2);
    scan_o.cl2  = ~unit_q[1];
    scan_o.frm  = (row_q == '0);
    scan_o.m    = m_q;
  end
endmodule

// File: rtl/lcd_com_src_sel.sv
module lcd_com_src_sel
  import lcd_com_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  master_i,
  input  logic  edge_rise_i,
  input  scan_t int_i,
  input  logic  ext_cl2_i,
  input  logic  ext_frm_i,
  input  logic  ext_m_i,
  output scan_t scan_o,
  output logic  shift_o
);
  logic cl2_d;

  always_comb begin
    scan_o.phi1 = int_i.phi1;
    scan_o.phi2 = int_i.phi2;
    scan_o.cl2  = master_i ? int_i.cl2 : ext_cl2_i;
    scan_o.frm  = master_i ? int_i.frm : ext_frm_i;
    scan_o.m    = master_i ? int_i.m   : ext_m_i;
  end

  // reset value matches the idle line-clock level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cl2_d <= 1'b1;
    else         cl2_d <= scan_o.cl2;
  end

  assign shift_o = edge_rise_i ? (scan_o.cl2 & ~cl2_d) : (~scan_o.cl2 & cl2_d);
endmodule

// File: rtl/lcd_com_shift.sv
module lcd_com_shift #(
  parameter int unsigned ROWS = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            dir_i,
  input  logic            link_a_i,
  input  logic            link_b_i,
  output logic [ROWS-1:0] stage_o,
  output logic            link_a_o,
  output logic            link_b_o,
  output logic            link_a_oe_o,
  output logic            link_b_oe_o
);
  logic [ROWS-1:0] stage_q;
  logic [ROWS-1:0] stage_d;
  logic            din;

  assign din = dir_i ? link_a_i : link_b_i;

  for (genvar k = 0; k < ROWS; k++) begin : g_stage
    logic from_lo;
    logic from_hi;
    if (k == 0) begin : g_first
      assign from_lo = din;
    end else begin : g_mid_lo
      assign from_lo = stage_q[k-1];
    end
    if (k == ROWS - 1) begin : g_last
      assign from_hi = din;
    end else begin : g_mid_hi
      assign from_hi = stage_q[k+1];
    end
    assign stage_d[k] = dir_i ? from_lo : from_hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '0;
    else if (shift_i) stage_q <= stage_d;
  end

  assign stage_o     = stage_q;
  assign link_a_o    = stage_q[0];
  assign link_b_o    = stage_q[ROWS-1];
  assign link_a_oe_o = ~dir_i;
  assign link_b_oe_o = dir_i;
endmodule

// File: rtl/lcd_com_timing.sv
module lcd_com_timing
  import lcd_com_pkg::*;
#(
  parameter int unsigned TICK_DIV = 175,
  parameter int unsigned ROWS     = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            master_i,
  input  logic            dir_i,
  input  logic            edge_rise_i,
  input  logic            ext_cl2_i,
  input  logic            ext_frm_i,
  input  logic            ext_m_i,
  input  logic            link_a_i,
  input  logic            link_b_i,
  output logic            link_a_o,
  output logic            link_b_o,
  output logic            link_a_oe_o,
  output logic            link_b_oe_o,
  output logic            phi1_o,
  output logic            phi2_o,
  output logic            cl2_o,
  output logic            frm_o,
  output logic            m_o,
  output logic [ROWS-1:0] row_o
);
  scan_t int_scan;
  scan_t out_scan;
  logic  shift;

  lcd_com_timebase #(.TICK_DIV(TICK_DIV), .ROWS(ROWS)) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (master_i),
    .scan_o (int_scan)
  );

  lcd_com_src_sel u_src_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_i    (master_i),
    .edge_rise_i (edge_rise_i),
    .int_i       (int_scan),
    .ext_cl2_i   (ext_cl2_i),
    .ext_frm_i   (ext_frm_i),
    .ext_m_i     (ext_m_i),
    .scan_o      (out_scan),
    .shift_o     (shift)
  );

  lcd_com_shift #(.ROWS(ROWS)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (shift),
    .dir_i       (dir_i),
    .link_a_i    (link_a_i),
    .link_b_i    (link_b_i),
    .stage_o     (row_o),
    .link_a_o    (link_a_o),
    .link_b_o    (link_b_o),
    .link_a_oe_o (link_a_oe_o),
    .link_b_oe_o (link_b_oe_o)
  );

  assign phi1_o = out_scan.phi1;
  assign phi2_o = out_scan.phi2;
  assign cl2_o  = out_scan.cl2;
  assign frm_o  = out_scan.frm;
  assign m_o    = out_scan.m;
endmodule

// File: rtl/lcd_com_timing_chk.sv
module lcd_com_timing_chk #(
  parameter int unsigned ROWS = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            master_i,
  input logic            phi1_o,
  input logic            phi2_o,
  input logic            cl2_o,
  input logic            frm_o,
  input logic            m_o,
  input logic [ROWS-1:0] row_o
);
  assert_no_phase_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi1_o || phi2_o);

  assert_cl2_rise_at_phi1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $rose(cl2_o)) |-> !phi1_o);

  assert_frm_on_line_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $rose(frm_o)) |-> $rose(cl2_o));

  assert_m_flips_at_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !$stable(m_o)) |-> frm_o);

  assert_row_moves_on_cl2_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $past(master_i, 2) && !$stable(row_o))
      |-> ($past(cl2_o) != $past(cl2_o, 2)));

  assert_slave_phase_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (phi1_o && phi2_o));
endmodule

bind lcd_com_timing lcd_com_timing_chk #(.ROWS(ROWS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .master_i (master_i),
  .phi1_o   (phi1_o),
  .phi2_o   (phi2_o),
  .cl2_o    (cl2_o),
  .frm_o    (frm_o),
  .m_o      (m_o),
  .row_o    (row_o)
);

// File: tb/lcd_com_timing_bench.sv
`timescale 1ns/1ps
module lcd_com_timing_bench;
  localparam int TD   = 2;
  localparam int ROWS = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i = 1'b1, dir_i = 1'b1, edge_rise_i = 1'b1;
  logic ext_cl2_i = 1'b1, ext_frm_i = 1'b0, ext_m_i = 1'b0;
  logic link_a_i = 1'b0, link_b_i = 1'b0;
  logic link_a_o, link_b_o, link_a_oe_o, link_b_oe_o;
  logic phi1_o, phi2_o, cl2_o, frm_o, m_o;
  logic [ROWS-1:0] row_o;

  always #2 clk = ~clk;

  lcd_com_timing #(.TICK_DIV(TD), .ROWS(ROWS)) u_lcd_com_timing (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i), .dir_i(dir_i),
    .edge_rise_i(edge_rise_i), .ext_cl2_i(ext_cl2_i), .ext_frm_i(ext_frm_i),
    .ext_m_i(ext_m_i), .link_a_i(link_a_i), .link_b_i(link_b_i),
    .link_a_o(link_a_o), .link_b_o(link_b_o), .link_a_oe_o(link_a_oe_o),
    .link_b_oe_o(link_b_oe_o), .phi1_o(phi1_o), .phi2_o(phi2_o), .cl2_o(cl2_o),
    .frm_o(frm_o), .m_o(m_o), .row_o(row_o)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int n;
  logic [ROWS-1:0] model;
  logic prev_cl2;
  int tok_a, tok_b;

  localparam int NCAT = 9;
  int err_cnt [NCAT];
  logic [63:0] f_act [NCAT];
  logic [63:0] f_exp [NCAT];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic note(input int c, input logic [63:0] act, input logic [63:0] exp);
    if (act !== exp) begin
      if (err_cnt[c] == 0) begin f_act[c] = act; f_exp[c] = exp; end
      err_cnt[c]++;
    end
  endtask

  task automatic do_reset(input bit mst, input bit dir, input bit er);
    @(negedge clk);
    rst_ni = 1'b0;
    master_i = mst; dir_i = dir; edge_rise_i = er;
    ext_cl2_i = 1'b1; ext_frm_i = 1'b0; ext_m_i = 1'b0;
    link_a_i = 1'b0; link_b_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    n = 0; model = '0; prev_cl2 = 1'b1;
    for (int c = 0; c < NCAT; c++) err_cnt[c] = 0;
  endtask

  // categories: 0 phi1,1 phi2,2 overlap,3 cl2,4 frm,5 m,6 row,7 pins,8 slave pass
  task automatic run_cycles(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      bit din, ec;
      int u, r, mm;
      @(negedge clk);
      n++;
      note(6, row_o, model);
      if (dir_i) note(7, {link_b_o, link_b_oe_o, link_a_oe_o}, {model[ROWS-1], 2'b10});
      else       note(7, {link_a_o, link_a_oe_o, link_b_oe_o}, {model[0], 2'b10});
      if (master_i) begin
        u  = (n / TD) % 4;
        r  = (n / (4*TD)) % ROWS;
        mm = (n / (4*TD*ROWS)) % 2;
        note(0, phi1_o, u != 0);
        note(1, phi2_o, u != 2);
        note(2, phi1_o | phi2_o, 1'b1);
        note(3, cl2_o, u < 2);
        note(4, frm_o, r == 0);
        note(5, m_o, mm[0]);
      end
      din = (n >= tok_a) && (n < tok_b);
      link_a_i = dir_i ? din : ~din;
      link_b_i = dir_i ? ~din : din;
      if (!master_i) begin
        ext_cl2_i = ((n / 5) % 2) == 0;
        ext_frm_i = ((n / 37) % 2) == 1;
        ext_m_i   = ((n / 53) % 2) == 1;
      end
      #1;
      if (!master_i)
        note(8, {phi1_o, phi2_o, cl2_o, frm_o, m_o},
                {2'b11, ext_cl2_i, ext_frm_i, ext_m_i});
      ec = edge_rise_i ? (cl2_o & ~prev_cl2) : (~cl2_o & prev_cl2);
      if (ec) begin
        if (dir_i) model = {model[ROWS-2:0], din};
        else       model = {din, model[ROWS-1:1]};
      end
      prev_cl2 = cl2_o;
    end
  endtask

  task automatic close_cat(input int c, input string req);
    chk(err_cnt[c] == 0, req, f_act[c], f_exp[c]);
  endtask

  task automatic t_reset_state;
    do_reset(1'b1, 1'b1, 1'b1);
    #1;
    chk(row_o == '0, "R1 row_o", row_o, 0);
    chk({m_o, frm_o, cl2_o, phi1_o, phi2_o} == 5'b01101, "R1 timing outputs",
        {m_o, frm_o, cl2_o, phi1_o, phi2_o}, 5'b01101);
  endtask

  task automatic t_master_timing;
    do_reset(1'b1, 1'b1, 1'b1);
    tok_a = -1; tok_b = -1;
    run_cycles(4*TD*ROWS*2 + 100);
    close_cat(0, "R2 phi1 pattern");
    close_cat(1, "R2 phi2 pattern");
    close_cat(2, "R2 non-overlap");
    close_cat(3, "R3 cl2 pattern");
    close_cat(4, "R4 frm on line 0");
    close_cat(5, "R5 m toggle per frame");
    close_cat(6, "R10 row_o idle");
  endtask

  task automatic t_walk_fwd_rise;
    do_reset(1'b1, 1'b1, 1'b1);
    tok_a = 3; tok_b = 3 + 4*TD;
    run_cycles(4*TD*ROWS + 60);
    close_cat(6, "R6 R8 R10 row_o dir=1 rising");
    close_cat(7, "R6 link_b exit and enables");
    chk(err_cnt[6] == 0 && model == '0, "R6 token left chain", model, 0);
  endtask

  task automatic t_walk_rev_fall;
    do_reset(1'b1, 1'b0, 1'b0);
    tok_a = 2; tok_b = 2 + 4*TD;
    run_cycles(4*TD*ROWS + 60);
    close_cat(6, "R7 R8 row_o dir=0 falling");
    close_cat(7, "R7 link_a exit and enables");
  endtask

  task automatic t_pattern_fwd_fall;
    do_reset(1'b1, 1'b1, 1'b0);
    tok_a = 10; tok_b = 10 + 4*TD*5;
    run_cycles(4*TD*20);
    close_cat(6, "R8 falling edge multi-bit dir=1");
    close_cat(7, "R6 pins multi-bit");
  endtask

  task automatic t_slave;
    do_reset(1'b0, 1'b0, 1'b1);
    tok_a = 12; tok_b = 40;
    run_cycles(900);
    close_cat(8, "R9 slave pass-through and idle phases");
    close_cat(6, "R9 slave shift on ext cl2");
    close_cat(7, "R7 slave pins");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_master_timing();
    t_walk_fwd_rise();
    t_walk_rev_fall();
    t_pattern_fwd_fall();
    t_slave();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule